// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block accepts up to 32 external interrupt request lines. Each line can be set to react to a low level, a high level, a falling edge, a rising edge or both edges. Every line passes through a two-stage synchronizer into the block clock. Edges are found by comparing two successive synchronized samples, so no input drives a flop's clock. A detected event is held in a per-line event bit until software clears it by writing a one to that bit.

A per-line enable mask decides which held events reach the CPU. The mask has one register that sets bits and one that clears them, so software never needs a read-modify-write. Each line has its own interrupt output, which is high while the line's event bit and enable bit are both set.

Software reaches the block through a plain 32-bit register bus with a byte address. Writes take effect on the clock edge where the write is asserted. Read data is combinational from the address.

Top module: `eisc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable mask, every event bit, every sense code and every interrupt output are zero. All registers read as zero.
- R2: A write to offset 0x08 sets each enable bit whose data bit is 1. Data bits that are 0 leave the matching enable bits unchanged.
- R3: A write to offset 0x04 clears each enable bit whose data bit is 1. Data bits that are 0 leave the matching enable bits unchanged. A read of 0x04 returns the enable mask, and a read of 0x08 returns zero.
- R4: Sense code 0x02 (high level) sets the event bit on every clock where the synchronized input is 1.
- R5: Sense code 0x01 (low level) sets the event bit on every clock where the synchronized input is 0.
- R6: Sense code 0x08 (rising edge) sets the event bit when the synchronized input goes from 0 to 1. The bit stays set after the input returns to 0.
- R7: Sense code 0x04 (falling edge) sets the event bit when the synchronized input goes from 1 to 0. A steady level or a rise sets nothing.
- R8: Sense code 0x0C (both edges) sets the event bit on either kind of transition.
- R9: Offset 0x100 reads the event bits. Writing a one to bit n clears event n, and zero bits have no effect. If line n is in a level mode and still at its active level, a clear leaves the bit set.
- R10: Line n's sense code sits in bits [5:0] at offset 0x180 + 4·n and reads back with the upper bits zero. Any code other than 0x01, 0x02, 0x04, 0x08 or 0x0C turns detection off for that line.
- R11: Output n is high exactly when event bit n and enable bit n are both 1. Offset 0x00 reads the event bits ANDed with the enable mask.
- R12: An input change made between two clock edges first shows on the outputs after the third rising edge that follows it. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 9 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_in | input | 32 | External request lines, asynchronous |
| irq_out | output | 32 | Per-line interrupt outputs |

## Verification
Register writes show in read data and outputs from the negative edge after the write edge. Input events pass three flop stages, so they reach the event bits and outputs after the third rising edge. Every check therefore samples at a negative edge, a whole number of cycles after the stimulus. The random phase runs a cycle model in the bench that steps on the same rising edges as the design and keeps the same stage counts. Its predicted outputs and register reads are compared at each negative edge. Directed cases sample the latency one edge early, to show nothing appears, and then at the due edge.

// File: rtl/eisc_pkg.sv
// Shared definitions for the external interrupt sense controller.
// Assumes byte addressing with 32-bit word-aligned registers.
package eisc_pkg;
    localparam int CFG_W = 6;

    localparam logic [CFG_W-1:0] CODE_LOW  = 6'h01;
    localparam logic [CFG_W-1:0] CODE_HIGH = 6'h02;
    localparam logic [CFG_W-1:0] CODE_FALL = 6'h04;
    localparam logic [CFG_W-1:0] CODE_RISE = 6'h08;
    localparam logic [CFG_W-1:0] CODE_BOTH = 6'h0C;

    typedef enum logic [2:0] {
        SNS_OFF, SNS_LOW, SNS_HIGH, SNS_FALL, SNS_RISE, SNS_BOTH
    } sense_e;

    // Map a stored code to a sense mode; unknown codes switch detection off.
    function automatic sense_e decode_sense(input logic [CFG_W-1:0] code);
        case (code)
            CODE_LOW:  return SNS_LOW;
            CODE_HIGH: return SNS_HIGH;
            CODE_FALL: return SNS_FALL;
            CODE_RISE: return SNS_RISE;
            CODE_BOTH: return SNS_BOTH;
            default:   return SNS_OFF;
        endcase
    endfunction
endpackage

// File: rtl/eisc_sync.sv
// Two-stage synchronizer for a vector of asynchronous request lines.
// Assumes each bit is independent; no bus coherency is kept across bits.
module eisc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Move each input through two flops into the block clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/eisc_line.sv
// One line's sense detector and held event bit.
// Assumes smp is already synchronized; a clear and a new hit in the same
// cycle leave the event bit set.
module eisc_line
    import eisc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic [CFG_W-1:0] cfg,
    input  logic             clr,
    output logic             det
);
    logic   prev;
    logic   hit;
    sense_e mode;

    assign mode = decode_sense(cfg);

    // Decide whether this cycle's sample is an event under the chosen mode.
    always_comb begin
        case (mode)
            SNS_LOW:  hit = ~smp;
            SNS_HIGH: hit = smp;
            SNS_FALL: hit = prev & ~smp;
            SNS_RISE: hit = smp & ~prev;
            SNS_BOTH: hit = smp ^ prev;
            default:  hit = 1'b0;
        endcase
    end

    // Keep the previous sample and hold events until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            det  <= 1'b0;
        end else begin
            prev <= smp;
            det  <= (det & ~clr) | hit;
        end
    end

    // R4: a high level keeps the event bit set on the following clock.
    a_r4_level_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CODE_HIGH && smp) |=> det);

    // R5: a low level keeps the event bit set on the following clock.
    a_r5_level_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CODE_LOW && !smp) |=> det);

    // R6: in rising mode a new event needs a 0-to-1 sample pair.
    a_r6_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg) == CODE_RISE && $rose(det)) |-> $past(smp && !prev));

    // R10: an unlisted code never raises the event bit.
    a_r10_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_sense(cfg) == SNS_OFF && !det) |=> !det);
endmodule

// File: rtl/eisc_regfile.sv
// Register bank: enable mask with set/clear ports, per-line sense codes,
// event clear strobes and the combinational read mux.
// Assumes word-aligned byte addresses and NUM_LINES <= DATA_W.
module eisc_regfile
    import eisc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_LINES-1:0]       det_in,
    output logic [NUM_LINES-1:0]       en_q,
    output logic [NUM_LINES*CFG_W-1:0] cfg_flat,
    output logic [NUM_LINES-1:0]       det_clr
);
    localparam logic [ADDR_W-1:0] OFS_VIEW  = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] OFS_MCLR  = ADDR_W'(12'h004);
    localparam logic [ADDR_W-1:0] OFS_MSET  = ADDR_W'(12'h008);
    localparam logic [ADDR_W-1:0] OFS_EVT   = ADDR_W'(12'h100);
    localparam logic [ADDR_W-1:0] OFS_CFG   = ADDR_W'(12'h180);
    localparam int                IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [ADDR_W-1:0] CFG_SPAN  = ADDR_W'(4 * NUM_LINES);

    logic [CFG_W-1:0]  cfg_q [NUM_LINES];
    logic [ADDR_W-1:0] cfg_off;
    logic              cfg_hit;
    logic [IDX_W-1:0]  cfg_idx;
    logic              wr;

    assign wr      = bus_sel && bus_we;
    assign cfg_off = bus_addr - OFS_CFG;
    assign cfg_hit = (bus_addr >= OFS_CFG) && (cfg_off < CFG_SPAN) && (bus_addr[1:0] == 2'b00);
    assign cfg_idx = cfg_off[IDX_W+1:2];

    // Enable mask: write-one-to-set and write-one-to-clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr && bus_addr == OFS_MSET) begin
            en_q <= en_q | bus_wdata[NUM_LINES-1:0];
        end else if (wr && bus_addr == OFS_MCLR) begin
            en_q <= en_q & ~bus_wdata[NUM_LINES-1:0];
        end
    end

    // Event clear strobes are live only during a write to the event register.
    assign det_clr = (wr && bus_addr == OFS_EVT) ? bus_wdata[NUM_LINES-1:0] : '0;

    // Per-line sense code storage.
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[n] <= '0;
            end else if (wr && cfg_hit && cfg_idx == IDX_W'(n)) begin
                cfg_q[n] <= bus_wdata[CFG_W-1:0];
            end
        end
        assign cfg_flat[n*CFG_W +: CFG_W] = cfg_q[n];
    end

    // Read data selection by address.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_VIEW)      bus_rdata = DATA_W'(det_in & en_q);
        else if (bus_addr == OFS_MCLR) bus_rdata = DATA_W'(en_q);
        else if (bus_addr == OFS_EVT)  bus_rdata = DATA_W'(det_in);
        else if (cfg_hit)              bus_rdata = DATA_W'(cfg_q[cfg_idx]);
    end

    // R2: bits written to the set port are enabled afterwards.
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_MSET) |=>
            ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    // R3: bits written to the clear port are disabled afterwards.
    a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_MCLR) |=> ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R2: without a mask write the mask does not move.
    a_r2_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == OFS_MSET || bus_addr == OFS_MCLR)) |=> $stable(en_q));
endmodule

// File: rtl/eisc_ctrl.sv
// Top of the external interrupt sense controller: synchronizer, one sense
// detector per line, the register bank and the per-line output gating.
// Assumes one clock domain for the bus; irq_in may be asynchronous.
module eisc_ctrl
    import eisc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0]       smp;
    logic [NUM_LINES-1:0]       det;
    logic [NUM_LINES-1:0]       en_q;
    logic [NUM_LINES-1:0]       det_clr;
    logic [NUM_LINES*CFG_W-1:0] cfg_flat;

    eisc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(smp)
    );

    eisc_regfile #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .det_in(det), .en_q(en_q), .cfg_flat(cfg_flat), .det_clr(det_clr)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        eisc_line u_line (
            .clk(clk), .rst_n(rst_n), .smp(smp[n]),
            .cfg(cfg_flat[n*CFG_W +: CFG_W]), .clr(det_clr[n]), .det(det[n])
        );
    end

    // Each line reaches the CPU only when its event is held and enabled.
    assign irq_out = det & en_q;

    // R1: the first cycle after reset shows no interrupt.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/tb_eisc_ctrl.sv
`timescale 1ns/1ps
module tb_eisc_ctrl;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [31:0] irq_out;

    int checks = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    eisc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    // ---------------- cycle model built from the requirements ----------------
    logic [31:0] m_s1, m_s2, m_prev, m_en, m_det;
    logic [5:0]  m_cfg [N];

    function automatic logic m_hit(input logic [5:0] c, input logic s, input logic p);
        case (c)
            6'h01: return ~s;
            6'h02: return s;
            6'h04: return p & ~s;
            6'h08: return s & ~p;
            6'h0C: return s ^ p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [8:0] a);
        if (a == 9'h000) return m_det & m_en;
        if (a == 9'h004) return m_en;
        if (a == 9'h100) return m_det;
        if (a >= 9'h180 && a[1:0] == 2'b00) return {26'd0, m_cfg[a[6:2]]};
        return 32'd0;
    endfunction

    always @(posedge clk) begin : mdl
        logic [31:0] hits;
        logic [31:0] clr;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_en <= '0; m_det <= '0;
            for (int i = 0; i < N; i++) m_cfg[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) hits[i] = m_hit(m_cfg[i], m_s2[i], m_prev[i]);
            clr = (bus_sel && bus_we && bus_addr == 9'h100) ? bus_wdata : 32'd0;
            m_det  <= (m_det & ~clr) | hits;
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= irq_in;
            if (bus_sel && bus_we) begin
                if (bus_addr == 9'h008) m_en <= m_en | bus_wdata;
                if (bus_addr == 9'h004) m_en <= m_en & ~bus_wdata;
                if (bus_addr >= 9'h180 && bus_addr[1:0] == 2'b00)
                    m_cfg[bus_addr[6:2]] <= bus_wdata[5:0];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_out", irq_out, 32'd0);
        bus_rd(9'h004, rd); chk("R1 mask", rd, 32'd0);
        bus_rd(9'h100, rd); chk("R1 events", rd, 32'd0);
        bus_rd(9'h180, rd); chk("R1 cfg0", rd, 32'd0);

        // R2 / R3 mask set and clear, zero bits no effect
        bus_wr(9'h008, 32'h0000_00F0);
        bus_wr(9'h008, 32'h0000_0001);
        bus_rd(9'h004, rd); chk("R2 set accumulates", rd, 32'h0000_00F1);
        bus_wr(9'h008, 32'h0);
        bus_rd(9'h004, rd); chk("R2 zero write", rd, 32'h0000_00F1);
        bus_wr(9'h004, 32'h0000_0030);
        bus_rd(9'h004, rd); chk("R3 clear", rd, 32'h0000_00C1);
        bus_rd(9'h008, rd); chk("R3 set port reads zero", rd, 32'd0);
        bus_wr(9'h004, 32'hFFFF_FFFF);
        bus_wr(9'h008, 32'h0000_000B);     // enable lines 0,1,3

        // R4 + R12 latency on line 0, high level
        bus_wr(9'h180, 32'h0000_0002);
        irq_in[0] = 1'b1;
        cyc(1); chk("R12 not after edge 1", {31'd0, irq_out[0]}, 32'd0);
        cyc(1); chk("R12 not after edge 2", {31'd0, irq_out[0]}, 32'd0);
        cyc(1); chk("R12 due after edge 3", {31'd0, irq_out[0]}, 32'd1);
        chk("R4 high level", {31'd0, irq_out[0]}, 32'd1);

        // R9 level stays set across a clear, then clears once low
        bus_wr(9'h100, 32'h0000_0001);
        bus_rd(9'h100, rd); chk("R9 level persists", rd & 32'h1, 32'h1);
        irq_in[0] = 1'b0;
        cyc(4);
        bus_wr(9'h100, 32'h0000_0000);
        bus_rd(9'h100, rd); chk("R9 zero write keeps", rd & 32'h1, 32'h1);
        bus_wr(9'h100, 32'h0000_0001);
        bus_rd(9'h100, rd); chk("R9 cleared", rd & 32'h1, 32'h0);
        chk("R11 out follows clear", {31'd0, irq_out[0]}, 32'd0);

        // R5 low level on line 3
        bus_wr(9'h18C, 32'h0000_0001);
        cyc(1);
        bus_rd(9'h100, rd); chk("R5 low level", rd & 32'h8, 32'h8);
        irq_in[3] = 1'b1; cyc(4);
        bus_wr(9'h100, 32'h0000_0008);
        bus_rd(9'h100, rd); chk("R5 cleared when high", rd & 32'h8, 32'h0);

        // R6 rising edge on line 1, short pulse
        bus_wr(9'h184, 32'h0000_0008);
        irq_in[1] = 1'b1; cyc(1); irq_in[1] = 1'b0; cyc(5);
        bus_rd(9'h100, rd); chk("R6 rise held", rd & 32'h2, 32'h2);

        // R7 falling edge on line 4
        bus_wr(9'h190, 32'h0000_0004);
        irq_in[4] = 1'b1; cyc(4);
        bus_rd(9'h100, rd); chk("R7 rise ignored", rd & 32'h10, 32'h0);
        irq_in[4] = 1'b0; cyc(4);
        bus_rd(9'h100, rd); chk("R7 fall seen", rd & 32'h10, 32'h10);
        chk("R11 disabled line quiet", {31'd0, irq_out[4]}, 32'd0);
        bus_rd(9'h000, rd); chk("R11 view masked", rd & 32'h12, 32'h2);

        // R8 both edges on line 5
        bus_wr(9'h194, 32'h0000_000C);
        irq_in[5] = 1'b1; cyc(4);
        bus_rd(9'h100, rd); chk("R8 rise", rd & 32'h20, 32'h20);
        bus_wr(9'h100, 32'h0000_0020); cyc(2);
        bus_rd(9'h100, rd); chk("R8 cleared", rd & 32'h20, 32'h0);
        irq_in[5] = 1'b0; cyc(4);
        bus_rd(9'h100, rd); chk("R8 fall", rd & 32'h20, 32'h20);

        // R10 unlisted code on line 2
        bus_wr(9'h188, 32'hFFFF_FFC3);
        bus_rd(9'h188, rd); chk("R10 readback", rd, 32'h0000_0003);
        irq_in[2] = 1'b1; cyc(3); irq_in[2] = 1'b0; cyc(4);
        bus_rd(9'h100, rd); chk("R10 no detect", rd & 32'h4, 32'h0);

        // Random phase against the cycle model
        for (int k = 0; k < 4000; k++) begin
            logic [8:0]  a;
            logic [31:0] d;
            logic [31:0] codes [6];
            codes = '{32'h01, 32'h02, 32'h04, 32'h08, 32'h0C, 32'h00};
            @(negedge clk);
            bus_sel = 1'b0; bus_we = 1'b0;
            #0.5;
            chk("R11 random irq_out", irq_out, m_det & m_en);
            case ($urandom_range(0, 5))
                0: a = 9'h000;
                1: a = 9'h004;
                2: a = 9'h008;
                3: a = 9'h100;
                default: a = 9'h180 + 9'($urandom_range(0, N - 1) * 4);
            endcase
            bus_rd(a, d);
            chk("R9 R10 random read", d, m_read(a));
            if ($urandom_range(0, 3) == 0) begin
                bus_sel = 1'b1; bus_we = 1'b1;
                if (a >= 9'h180)
                    bus_wdata = ($urandom_range(0, 7) == 0) ? $urandom : codes[$urandom_range(0, 5)];
                else
                    bus_wdata = $urandom & $urandom;
            end
            irq_in = irq_in ^ ($urandom & $urandom & $urandom);
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule